// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on one output line. Every frame begins with a low start bit. The data bits follow, least significant first, then an optional parity bit, then one or two high stop bits. Between frames the line rests high. The frame format comes from four input pins. It can change at any time, but the shifter latches it only when a frame starts.

Words enter through a valid/ready port. They land in a one-entry holding buffer that sits in front of the shift register. If a word is waiting when the last stop bit of a frame ends, the next start bit goes out on that same baud tick, with no idle time between the frames. Timing comes from a one-cycle `baud_tick` enable supplied from outside, and each bit lasts exactly one tick period.

Two flags report progress, and each can raise an interrupt. The buffer-empty flag is the ready signal. The transmit-complete flag marks that the line has gone quiet with nothing left to send.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `wr_ready` is 1, `tx_done` is 0 and both interrupt outputs are 0.
- R2: A frame is one start bit (0), then the data bits LSB first, then the optional parity bit, then the stop bits (1). Each bit lasts one baud tick period, and `tx_line` changes only in the cycle after a `baud_tick`. When idle, the line is 1.
- R3: `fmt_data_bits` selects 5 to 9 data bits. A value below 5 is treated as 5, and a value above 9 is treated as 9.
- R4: When `fmt_parity_en` is 1, a parity bit follows the data. With `fmt_parity_odd` = 0 (even), the data bits and the parity bit together hold an even number of ones. With `fmt_parity_odd` = 1 (odd), they hold an odd number.
- R5: `fmt_two_stop` = 1 sends two stop bits; 0 sends one.
- R6: The format inputs are sampled when a frame's start bit is loaded. Changing them during a frame has no effect on that frame.
- R7: The holding buffer stores one word. `wr_ready` (the buffer-empty flag) is 1 exactly when the buffer is empty. A write is accepted when `wr_valid` and `wr_ready` are both 1. A `wr_valid` while the buffer is full is ignored.
- R8: If a word is buffered when the last stop bit ends, its start bit begins on that same tick. A new frame never starts between ticks.
- R9: `tx_done` is set when the last stop bit ends with the buffer empty. It is cleared by an accepted write or by `done_ack`. An accepted write in the setting cycle leaves it clear, and a set in the same cycle as `done_ack` leaves it set.
- R10: `irq_empty` is `wr_ready` AND `irq_empty_en`, and `irq_done` is `tx_done` AND `irq_done_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| fmt_data_bits | input | 4 | Data bit count, 5..9 |
| fmt_two_stop | input | 1 | 1 = two stop bits |
| fmt_parity_en | input | 1 | 1 = append a parity bit |
| fmt_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Word to send (low bits used) |
| wr_ready | output | 1 | Buffer empty, write is accepted |
| done_ack | input | 1 | Clears the transmit-complete flag |
| irq_empty_en | input | 1 | Enables the buffer-empty interrupt |
| irq_done_en | input | 1 | Enables the transmit-complete interrupt |
| tx_line | output | 1 | Serial output |
| tx_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | Transmit-complete interrupt |

## Verification
The end of a final stop bit can land in the same cycle as a write or as an acknowledge. That cycle decides both whether the shifter goes idle and what happens to the complete flag. The bench follows its model until one bit of the current frame remains. It then drives the tick together with `wr_valid` in one run and together with a held `done_ack` in another. The model applies the stated priorities, write over set and set over acknowledge, and the flag is compared with the model on every cycle.

// File: rtl/uft_pkg.sv
// Shared constants and types for the serial transmitter.
// Assumes the data word is never narrower than the smallest frame size.
package uft_pkg;
    localparam int MIN_DATA_BITS = 5;

    typedef struct packed {
        logic [3:0] nbits;     // requested data bit count
        logic       two_stop;  // 1 = two stop bits
        logic       par_en;    // 1 = parity bit present
        logic       par_odd;   // 1 = odd parity
    } fmt_t;
endpackage

// File: rtl/uft_hold_buf.sv
// One-entry holding buffer between the write port and the shifter.
// Assumes load is asserted only while full, so a fill and a drain never
// happen in the same cycle.
module uft_hold_buf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic              accept,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    // Accept a write only into an empty slot.
    always_comb accept = wr_valid && !full;

    // Fill on accept, drain when the shifter takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (accept) begin
            full <= 1'b1;
            word <= wr_data;
        end else if (load) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uft_frame_shifter.sv
// Builds a whole frame (start, data LSB first, parity, stops) when a word
// is taken, then shifts it out one bit per baud tick.
// Assumes DATA_W >= MIN_DATA_BITS and a one-cycle tick.
module uft_frame_shifter
    import uft_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_word,
    input  fmt_t              fmt,
    output logic              load,
    output logic              go_idle,
    output logic              line
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int IDX_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   len;
    logic               busy;
    logic               last_bit;
    int                 nb;
    logic               par;

    // Decode the end of the current bit and the load or idle decision.
    always_comb begin
        last_bit = busy && (left == CNT_W'(1));
        load     = tick && buf_full && (!busy || last_bit);
        go_idle  = tick && last_bit && !buf_full;
    end

    // Compose the next frame from the buffered word and the current format.
    always_comb begin
        nb = int'(fmt.nbits);
        if (nb < MIN_DATA_BITS) nb = MIN_DATA_BITS;
        if (nb > DATA_W)        nb = DATA_W;
        par      = fmt.par_odd;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nb) begin
                frame[i + 1] = buf_word[i];
                par          = par ^ buf_word[i];
            end
        end
        if (fmt.par_en) frame[IDX_W'(nb + 1)] = par;
        len = CNT_W'(2 + nb + int'(fmt.par_en) + int'(fmt.two_stop));
    end

    // Load a frame, or shift one bit per tick until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            shreg <= frame;
            left  <= len;
        end else if (tick && busy) begin
            if (last_bit) busy <= 1'b0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - CNT_W'(1);
        end
    end

    // Drive the current bit, or high when idle.
    always_comb line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uft_done_flag.sv
// Transmit-complete flag. A write beats the set, and the set beats the
// acknowledge. Assumes go_idle is a one-cycle event.
module uft_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic go_idle,
    input  logic accept,
    input  logic ack,
    output logic done
);
    // Update the flag with the fixed priority write > set > ack.
    always_ff @(posedge clk) begin
        if (!rst_n)       done <= 1'b0;
        else if (accept)  done <= 1'b0;
        else if (go_idle) done <= 1'b1;
        else if (ack)     done <= 1'b0;
    end
endmodule

// File: rtl/uart_frame_tx.sv
// Top of the asynchronous serial transmitter: write buffer, frame shifter,
// complete flag and interrupt gating. Assumes baud_tick is a single-cycle
// enable produced outside the block.
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [3:0]        fmt_data_bits,
    input  logic              fmt_two_stop,
    input  logic              fmt_parity_en,
    input  logic              fmt_parity_odd,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              done_ack,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    output logic              tx_line,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);
    logic              accept;
    logic              buf_full;
    logic [DATA_W-1:0] buf_word;
    logic              load;
    logic              go_idle;
    fmt_t              fmt;

    // Gather the format pins into one struct.
    always_comb fmt = '{nbits: fmt_data_bits, two_stop: fmt_two_stop,
                        par_en: fmt_parity_en, par_odd: fmt_parity_odd};

    uft_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .load(load), .accept(accept), .full(buf_full), .word(buf_word)
    );

    uft_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .buf_full(buf_full),
        .buf_word(buf_word), .fmt(fmt), .load(load), .go_idle(go_idle),
        .line(tx_line)
    );

    uft_done_flag u_done (
        .clk(clk), .rst_n(rst_n), .go_idle(go_idle), .accept(accept),
        .ack(done_ack), .done(tx_done)
    );

    // Report buffer space and gate both interrupts.
    always_comb begin
        wr_ready  = !buf_full;
        irq_empty = wr_ready && irq_empty_en;
        irq_done  = tx_done && irq_done_en;
    end
endmodule

// File: rtl/uft_checker.sv
// Port-level properties of the transmitter, bound to the top module.
module uft_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_valid,
    input logic wr_ready,
    input logic done_ack,
    input logic tx_line,
    input logic tx_done
);
    // R2: the line moves only after a tick
    a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_line));

    // R7: an accepted write fills the single slot
    a_r7_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    // R8: the slot drains only when a frame starts on a tick
    a_r8_drain_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ready) |-> $past(baud_tick));

    // R9: completion appears only at a tick
    a_r9_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(baud_tick));

    // R9: an accepted write clears the flag
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !tx_done);

    // R9: an acknowledge with no competing set clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ack && !baud_tick) |=> !tx_done);
endmodule

bind uart_frame_tx uft_checker u_uft_checker (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .done_ack(done_ack), .tx_line(tx_line),
    .tx_done(tx_done)
);

// File: tb/uart_frame_tx_bench.sv
// Bench with a behavioural reference model, compared on every cycle.
module uart_frame_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [3:0] fmt_data_bits = 4'd8;
    logic       fmt_two_stop = 1'b0;
    logic       fmt_parity_en = 1'b0;
    logic       fmt_parity_odd = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       wr_ready;
    logic       done_ack = 1'b0;
    logic       irq_empty_en = 1'b0;
    logic       irq_done_en = 1'b0;
    logic       tx_line, tx_done, irq_empty, irq_done;

    always #5 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (.*);

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    int    tick_per = 4;
    int    tick_cnt = 0;
    bit    force_tick = 0;
    string line_tag = "R2";

    // reference model state
    bit   m_q[$];
    bit   m_busy = 0;
    bit   m_full = 0;
    int   m_word = 0;
    bit   m_done = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic model_update();
        bit accept, ending, load;
        int nb;
        bit par;
        accept = wr_valid && !m_full;
        ending = baud_tick && m_busy && (m_q.size() == 1);
        load   = baud_tick && m_full && (!m_busy || m_q.size() == 1);
        if (baud_tick && m_busy) void'(m_q.pop_front());
        if (load) begin
            nb = int'(fmt_data_bits);
            if (nb < 5) nb = 5;
            if (nb > 9) nb = 9;
            par = fmt_parity_odd;
            m_q.push_back(1'b0);
            for (int i = 0; i < nb; i++) begin
                m_q.push_back(m_word[i]);
                par ^= m_word[i];
            end
            if (fmt_parity_en) m_q.push_back(par);
            m_q.push_back(1'b1);
            if (fmt_two_stop) m_q.push_back(1'b1);
            m_busy = 1;
        end else if (ending) begin
            m_busy = 0;
        end
        if (accept)                m_done = 0;
        else if (ending && !m_full) m_done = 1;
        else if (done_ack)         m_done = 0;
        if (load) m_full = 0;
        if (accept) begin
            m_full = 1;
            m_word = int'(wr_data);
        end
    endtask

    task automatic compare();
        chk(line_tag, tx_line, m_busy ? m_q[0] : 1'b1);
        chk("R7 wr_ready", wr_ready, !m_full);
        chk("R9 tx_done", tx_done, m_done);
        chk("R10 irq_empty", irq_empty, !m_full && irq_empty_en);
        chk("R10 irq_done", irq_done, m_done && irq_done_en);
    endtask

    task automatic step();
        baud_tick = force_tick || (tick_cnt == tick_per - 1);
        @(posedge clk);
        model_update();
        tick_cnt = (tick_cnt >= tick_per - 1) ? 0 : tick_cnt + 1;
        cycles++;
        @(negedge clk);
        compare();
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    endtask

    task automatic send(input int w);
        while (m_full) step();
        wr_data  = 9'(w);
        wr_valid = 1'b1;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (m_full || m_busy) step();
        repeat (3) step();
    endtask

    task automatic set_fmt(input int nb, input bit two, input bit pe, input bit po);
        fmt_data_bits  = 4'(nb);
        fmt_two_stop   = two;
        fmt_parity_en  = pe;
        fmt_parity_odd = po;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 line", tx_line, 1'b1);
        chk("R1 ready", wr_ready, 1'b1);
        chk("R1 done", tx_done, 1'b0);
        chk("R1 irq_empty", irq_empty, 1'b0);
        chk("R1 irq_done", irq_done, 1'b0);
        rst_n = 1'b1;
        step();

        // R2: basic frame, 8 data bits, no parity, one stop
        line_tag = "R2 frame";
        set_fmt(8, 0, 0, 0);
        send(9'h0A5);
        drain();

        // R3: every length, including clamped values
        line_tag = "R3 length";
        for (int n = 3; n <= 12; n++) begin
            set_fmt(n, 0, 0, 0);
            send(9'h1B3);
            drain();
        end

        // R4: even and odd parity on several words
        line_tag = "R4 parity";
        tick_per = 3;
        for (int k = 0; k < 4; k++) begin
            set_fmt(5 + k, 0, 1, k[0]);
            send(9'h155 ^ (k * 37));
            drain();
        end

        // R5: two stop bits, with an even-parity 9-bit word
        line_tag = "R5 stop";
        set_fmt(9, 1, 1, 0);
        send(9'h1FF);
        drain();
        set_fmt(6, 1, 0, 0);
        send(9'h02A);
        drain();

        // R8 and R7: back-to-back words, and a write while full is ignored
        line_tag = "R8 back-to-back";
        irq_empty_en = 1'b1;
        irq_done_en  = 1'b1;
        tick_per = 1;
        set_fmt(7, 0, 1, 1);
        send(9'h011);
        send(9'h022);
        wr_data = 9'h0EE; wr_valid = 1'b1;   // R7: slot full, must be dropped
        step();
        step();
        wr_valid = 1'b0;
        send(9'h033);
        drain();

        // R6: change the format in the middle of a frame
        line_tag = "R6 format hold";
        tick_per = 2;
        set_fmt(8, 0, 0, 0);
        send(9'h0C3);
        repeat (6) step();
        set_fmt(5, 1, 1, 1);
        drain();

        // R9: write in the same cycle as the end of the last stop bit
        line_tag = "R9 write at end";
        tick_per = 1000;
        tick_cnt = 0;
        set_fmt(5, 0, 0, 0);
        send(9'h015);
        force_tick = 1;
        while (!(m_busy && m_q.size() == 1)) step();
        wr_data = 9'h00A; wr_valid = 1'b1;
        step();
        wr_valid = 1'b0;
        drain();

        // R9: acknowledge held while the last stop bit ends
        line_tag = "R9 ack at end";
        send(9'h016);
        while (!(m_busy && m_q.size() == 1)) step();
        done_ack = 1'b1;
        step();
        done_ack = 1'b0;
        step();
        chk("R9 set beats ack", tx_done, 1'b1);
        done_ack = 1'b1;
        force_tick = 0;
        step();
        done_ack = 1'b0;
        chk("R9 ack clears", tx_done, 1'b0);

        // R10: interrupt enables off mask the outputs
        irq_empty_en = 1'b0;
        irq_done_en  = 1'b0;
        force_tick = 1;
        send(9'h001);
        drain();
        chk("R10 masked irq_done", irq_done, 1'b0);

        finish_run();
    end
endmodule